// File: doc/BRIEF.md
# Bounded Buffer-Window DMA Engine

This block copies a run of bytes between an external memory port and a 4 KiB internal buffer. The buffer is seen at a fixed window of the device address space, from 0x40000 to 0x40FFF. Software writes the source address, the destination address, the byte count and finally a command word. The command word picks the direction and says whether completion raises an interrupt. After a fixed start delay the engine checks that the internal-side range sits entirely in the window. If it does, the engine streams the bytes one 32-bit word per memory handshake. It then clears its run bit and, when asked, pulses an interrupt request towards an interrupt status unit. A range that falls outside the window is not copied: a sticky error flag is set and run is cleared.

The external-side address is cut to a parameterised width before it reaches the memory port. All four registers are frozen while a transfer is under way.

Top module: `dma_bufcopy`

## Requirements
- R1: The registers sit at source 0x80, destination 0x88, count 0x90 and command 0x98. An access of size 8 moves all 64 bits. An access of size 4 writes the low 32 bits, clears the upper 32 bits, and reads back the low 32 bits zero-extended. Any other offset reads as zero.
- R2: A write whose size is neither 4 nor 8 changes nothing. A read of such a size returns all ones.
- R3: A command write with bit 0 (run) clear is ignored entirely. The command register keeps its old value and no transfer starts.
- R4: While run is set, writes to any of the four registers are ignored.
- R5: After a command write with run set, the first memory request appears exactly StartDelay clock cycles after the edge that took the write.
- R6: Command bit 1 selects the direction: 0 copies external memory into the buffer, 1 copies the buffer out to external memory. Each handshake (memReq with memAck) moves the word at external byte address base+4k. memBe bit i marks the byte at address+i, carried on data bits 8i+7:8i. Only the final word of a count that is not a multiple of 4 has a partial mask, and it covers the low bytes.
- R7: The external memory address is the external-side register (the source for direction 0, the destination for direction 1) cut to its low ExtAddrW bits, plus the offset of the word.
- R8: The internal-side address minus 0x40000 indexes the buffer. A transfer is refused when the count is zero or when [address, address+count) does not lie wholly within 0x40000..0x40FFF. A refused transfer issues no memory request and no interrupt, sets the sticky error flag and clears run.
- R9: On completion, run is cleared. If command bit 2 is set, irqPulse is high for exactly one cycle, in the first cycle where run reads back as 0; otherwise irqPulse stays low.
- R10: After reset, all registers read zero, and memReq, irqPulse and errFlag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regSize | input | 4 | Access size in bytes |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data (combinational) |
| memReq | output | 1 | Memory word request, held until acknowledged |
| memWe | output | 1 | 1 = write to external memory, 0 = read |
| memAddr | output | ExtAddrW | External byte address |
| memBe | output | 4 | Byte enables |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Handshake accept; read data valid with it |
| memRdata | input | 32 | Read data |
| irqPulse | output | 1 | One-cycle completion interrupt request |
| errFlag | output | 1 | Sticky range-violation flag |

## Verification
Register reads are combinational, so the bench samples them one time step after it drives the offset. Register writes take effect at the next rising edge. From the edge that takes a starting command write, the bench counts falling edges and expects the first memory request at the falling edge numbered StartDelay. It polls the run bit at every falling edge and watches irqPulse over the same samples. The interrupt and the cleared run bit must be seen together, at the falling edge after the last handshake. Memory contents are compared only after run reads 0, against a bench shadow of the buffer.

// File: rtl/dma_bufcopy_pkg.sv
package dma_bufcopy_pkg;
  localparam logic [7:0] OffSrc = 8'h80;
  localparam logic [7:0] OffDst = 8'h88;
  localparam logic [7:0] OffCnt = 8'h90;
  localparam logic [7:0] OffCmd = 8'h98;

  localparam int CmdRunBit = 0;
  localparam int CmdDirBit = 1;
  localparam int CmdIrqBit = 2;

  typedef enum logic [1:0] {
    StIdle = 2'd0,
    StWait = 2'd1,
    StMove = 2'd2
  } xferState_t;

  typedef struct packed {
    logic clearBeat;
    logic nextBeat;
    logic bufWrite;
  } dpStrobe_t;
endpackage

// File: rtl/dma_bufcopy_dp.sv
module dma_bufcopy_dp
  import dma_bufcopy_pkg::*;
#(
  parameter int          ExtAddrW = 28,
  parameter int          BufBytes = 4096,
  parameter logic [63:0] BufBase  = 64'h40000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dpStrobe_t           strobe,
  input  logic [63:0]         srcReg,
  input  logic [63:0]         dstReg,
  input  logic [63:0]         cntReg,
  input  logic                dirOut,
  input  logic [31:0]         memRdata,
  output logic [ExtAddrW-1:0] memAddr,
  output logic [3:0]          memBe,
  output logic [31:0]         memWdata,
  output logic                lastBeat,
  output logic                rangeOk
);
  localparam int          BufAW  = $clog2(BufBytes);
  localparam int          BeatW  = $clog2(BufBytes / 4) + 1;
  localparam logic [63:0] BufLen = 64'(BufBytes);

  logic [7:0]       bufMem [BufBytes];
  logic [BeatW-1:0] beatIdx;
  logic [63:0]      intAddr, extAddr, intOffFull, byteDone, remain;
  logic [BufAW-1:0] laneIdx [4];

  assign intAddr    = dirOut ? srcReg : dstReg;
  assign extAddr    = dirOut ? dstReg : srcReg;
  assign intOffFull = intAddr - BufBase;
  assign byteDone   = 64'({beatIdx, 2'b00});
  assign remain     = cntReg - byteDone;
  assign lastBeat   = (remain <= 64'd4);

  assign rangeOk = (intAddr >= BufBase) && (intOffFull < BufLen) &&
                   (cntReg != 64'd0) && (cntReg <= BufLen) &&
                   ((intOffFull + cntReg) <= BufLen);

  assign memAddr = extAddr[ExtAddrW-1:0] + byteDone[ExtAddrW-1:0];

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign memBe[i]          = (remain > 64'(i));
    assign laneIdx[i]        = intOffFull[BufAW-1:0] + byteDone[BufAW-1:0] + BufAW'(i);
    assign memWdata[8*i+7:8*i] = bufMem[laneIdx[i]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beatIdx <= '0;
    end else if (strobe.clearBeat) begin
      beatIdx <= '0;
    end else if (strobe.nextBeat) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.bufWrite) begin
      for (int i = 0; i < 4; i++) begin
        if (memBe[i]) bufMem[laneIdx[i]] <= memRdata[8*i+:8];
      end
    end
  end
endmodule

// File: rtl/dma_bufcopy_ctrl.sv
module dma_bufcopy_ctrl
  import dma_bufcopy_pkg::*;
#(
  parameter int StartDelay = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [3:0]  regSize,
  input  logic [63:0] regWrData,
  output logic [63:0] regRdData,
  input  logic        memAck,
  input  logic        rangeOk,
  input  logic        lastBeat,
  output logic [63:0] srcReg,
  output logic [63:0] dstReg,
  output logic [63:0] cntReg,
  output logic        dirOut,
  output logic        memReq,
  output logic        memWe,
  output dpStrobe_t   strobe,
  output logic        irqPulse,
  output logic        errFlag,
  output logic        runFlag
);
  localparam int DlyW = $clog2(StartDelay + 1);

  xferState_t      state;
  logic [63:0]     cmdReg;
  logic [DlyW-1:0] dly;
  logic            sizeOk, wrOpen, startHit;
  logic [63:0]     wrVal, rdSel;

  assign sizeOk   = (regSize == 4'd4) || (regSize == 4'd8);
  assign wrVal    = (regSize == 4'd4) ? {32'b0, regWrData[31:0]} : regWrData;
  assign wrOpen   = regWrEn && sizeOk && !cmdReg[CmdRunBit];
  assign startHit = wrOpen && (regAddr == OffCmd) && regWrData[CmdRunBit];
  assign runFlag  = cmdReg[CmdRunBit];
  assign dirOut   = cmdReg[CmdDirBit];
  assign memReq   = (state == StMove);
  assign memWe    = cmdReg[CmdDirBit];

  always_comb begin
    unique case (regAddr)
      OffSrc:  rdSel = srcReg;
      OffDst:  rdSel = dstReg;
      OffCnt:  rdSel = cntReg;
      OffCmd:  rdSel = cmdReg;
      default: rdSel = '0;
    endcase
    if (!sizeOk)                regRdData = '1;
    else if (regSize == 4'd4)   regRdData = {32'b0, rdSel[31:0]};
    else                        regRdData = rdSel;
  end

  always_comb begin
    strobe.clearBeat = startHit;
    strobe.nextBeat  = (state == StMove) && memAck;
    strobe.bufWrite  = (state == StMove) && memAck && !cmdReg[CmdDirBit];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= StIdle;
      srcReg   <= '0;
      dstReg   <= '0;
      cntReg   <= '0;
      cmdReg   <= '0;
      dly      <= '0;
      irqPulse <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      irqPulse <= 1'b0;
      unique case (state)
        StIdle: begin
          if (wrOpen) begin
            if (regAddr == OffSrc) srcReg <= wrVal;
            if (regAddr == OffDst) dstReg <= wrVal;
            if (regAddr == OffCnt) cntReg <= wrVal;
          end
          if (startHit) begin
            cmdReg <= wrVal;
            dly    <= '0;
            state  <= StWait;
          end
        end
        StWait: begin
          if (dly == DlyW'(StartDelay - 1)) begin
            if (rangeOk) begin
              state <= StMove;
            end else begin
              errFlag           <= 1'b1;
              cmdReg[CmdRunBit] <= 1'b0;
              state             <= StIdle;
            end
          end else begin
            dly <= dly + 1'b1;
          end
        end
        StMove: begin
          if (memAck && lastBeat) begin
            cmdReg[CmdRunBit] <= 1'b0;
            irqPulse          <= cmdReg[CmdIrqBit];
            state             <= StIdle;
          end
        end
        default: state <= StIdle;
      endcase
    end
  end
endmodule

// File: rtl/dma_bufcopy.sv
module dma_bufcopy
  import dma_bufcopy_pkg::*;
#(
  parameter int          ExtAddrW   = 28,
  parameter int          StartDelay = 100,
  parameter int          BufBytes   = 4096,
  parameter logic [63:0] BufBase    = 64'h40000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regWrEn,
  input  logic [7:0]          regAddr,
  input  logic [3:0]          regSize,
  input  logic [63:0]         regWrData,
  output logic [63:0]         regRdData,
  output logic                memReq,
  output logic                memWe,
  output logic [ExtAddrW-1:0] memAddr,
  output logic [3:0]          memBe,
  output logic [31:0]         memWdata,
  input  logic                memAck,
  input  logic [31:0]         memRdata,
  output logic                irqPulse,
  output logic                errFlag
);
  dpStrobe_t   strobe;
  logic [63:0] srcReg, dstReg, cntReg;
  logic        dirOut, rangeOk, lastBeat, runFlag;

  dma_bufcopy_ctrl #(.StartDelay(StartDelay)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regAddr(regAddr), .regSize(regSize),
    .regWrData(regWrData), .regRdData(regRdData),
    .memAck(memAck), .rangeOk(rangeOk), .lastBeat(lastBeat),
    .srcReg(srcReg), .dstReg(dstReg), .cntReg(cntReg), .dirOut(dirOut),
    .memReq(memReq), .memWe(memWe), .strobe(strobe),
    .irqPulse(irqPulse), .errFlag(errFlag), .runFlag(runFlag)
  );

  dma_bufcopy_dp #(
    .ExtAddrW(ExtAddrW), .BufBytes(BufBytes), .BufBase(BufBase)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .srcReg(srcReg), .dstReg(dstReg), .cntReg(cntReg), .dirOut(dirOut),
    .memRdata(memRdata), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .lastBeat(lastBeat), .rangeOk(rangeOk)
  );
endmodule

// File: rtl/dma_bufcopy_chk.sv
module dma_bufcopy_chk #(
  parameter int ExtAddrW   = 28,
  parameter int StartDelay = 100
) (
  input logic                clk,
  input logic                rst_n,
  input logic                memReq,
  input logic                memAck,
  input logic [ExtAddrW-1:0] memAddr,
  input logic [3:0]          memBe,
  input logic                irqPulse,
  input logic                errFlag,
  input logic                runFlag
);
  logic [31:0] sinceRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sinceRun <= '0;
    else if (!runFlag)           sinceRun <= '0;
    else if (sinceRun != '1)     sinceRun <= sinceRun + 1'b1;
  end

  p_req_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> runFlag);

  p_first_req_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memReq) |-> (sinceRun == 32'(StartDelay)));

  p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memBe));

  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memBe == 4'h1 || memBe == 4'h3 || memBe == 4'h7 || memBe == 4'hF));

  p_irq_at_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> !runFlag && $past(runFlag));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |=> !irqPulse);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);
endmodule

bind dma_bufcopy dma_bufcopy_chk #(.ExtAddrW(ExtAddrW), .StartDelay(StartDelay)) u_chk (
  .clk(clk), .rst_n(rst_n), .memReq(memReq), .memAck(memAck),
  .memAddr(memAddr), .memBe(memBe), .irqPulse(irqPulse),
  .errFlag(errFlag), .runFlag(runFlag)
);

// File: tb/dma_bufcopy_tb.sv
module dma_bufcopy_tb;
  localparam int ClkPeriod = 10;
  localparam int AW        = 28;
  localparam int Dly       = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h0;
  logic [3:0]  regSize = 4'd8;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        memReq, memWe, memAck = 1'b0;
  logic [AW-1:0] memAddr;
  logic [3:0]  memBe;
  logic [31:0] memWdata, memRdata = '0;
  logic        irqPulse, errFlag;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] ext [65536];
  logic [7:0] shadow [4096];
  logic [7:0] saved [65536];

  always #(ClkPeriod/2) clk = ~clk;

  dma_bufcopy #(.ExtAddrW(AW), .StartDelay(Dly)) u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regSize(regSize), .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .irqPulse(irqPulse), .errFlag(errFlag)
  );

  // external memory model: acknowledge at random, commit writes at the edge
  always @(negedge clk) begin
    memAck <= memReq && ($urandom_range(3) != 0);
    for (int i = 0; i < 4; i++) memRdata[8*i+:8] <= ext[16'(memAddr[15:0] + 16'(i))];
  end
  always @(posedge clk) begin
    if (memReq && memAck && memWe)
      for (int i = 0; i < 4; i++)
        if (memBe[i]) ext[16'(memAddr[15:0] + 16'(i))] <= memWdata[8*i+:8];
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    regAddr = a; regSize = sz; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, input logic [3:0] sz, output logic [63:0] d);
    regAddr = a; regSize = sz;
    #1 d = regRdData;
  endtask

  // program and run; returns observations of the run
  task automatic doXfer(input logic [63:0] src, input logic [63:0] dst,
                        input logic [63:0] cnt, input logic [63:0] cmd,
                        output int irqs, output int firstReq, output logic [AW-1:0] firstAddr,
                        output int reqCycles);
    logic [63:0] rd;
    int k;
    irqs = 0; firstReq = -1; firstAddr = '0; reqCycles = 0;
    regWrite(8'h80, 4'd8, src);
    regWrite(8'h88, 4'd8, dst);
    regWrite(8'h90, 4'd8, cnt);
    regWrite(8'h98, 4'd8, cmd);
    k = 0;
    forever begin
      regRead(8'h98, 4'd8, rd);
      if (memReq) begin
        reqCycles++;
        if (firstReq < 0) begin firstReq = k; firstAddr = memAddr; end
      end
      if (irqPulse) irqs++;
      if (!rd[0]) break;
      @(negedge clk);
      k++;
      if (k > 30000) begin check(1'b0, "R9 run never cleared", 64'(k), 0); break; end
    end
    // one more sample to catch a stray late pulse
    @(negedge clk);
    if (irqPulse) irqs++;
  endtask

  function automatic int cmpOut(input int off, input int dbase, input int cnt);
    int bad = 0;
    for (int i = 0; i < cnt; i++)
      if (ext[16'(dbase + i)] !== shadow[off + i]) bad++;
    for (int i = cnt; i < cnt + 4; i++)
      if (ext[16'(dbase + i)] !== saved[16'(dbase + i)]) bad++;
    return bad;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    int irqs, first, reqs, off, cnt, bad;
    logic [AW-1:0] fa;
    logic [63:0] src, dst, hiJunk, cmd;

    void'($urandom(32'd20150126));
    for (int i = 0; i < 65536; i++) begin ext[i] = 8'($urandom); saved[i] = ext[i]; end
    for (int i = 0; i < 4096; i++) shadow[i] = 8'hxx;

    repeat (3) @(negedge clk);
    // R10: reset state
    regRead(8'h80, 4'd8, rd); check(rd == 0, "R10 src reset", rd, 0);
    regRead(8'h88, 4'd8, rd); check(rd == 0, "R10 dst reset", rd, 0);
    regRead(8'h90, 4'd8, rd); check(rd == 0, "R10 cnt reset", rd, 0);
    regRead(8'h98, 4'd8, rd); check(rd == 0, "R10 cmd reset", rd, 0);
    check(!memReq && !irqPulse && !errFlag, "R10 outputs low",
          {61'b0, memReq, irqPulse, errFlag}, 0);
    rst_n = 1'b1;

    // R1: sizes and offsets
    regWrite(8'h80, 4'd8, 64'h1234_5678_9abc_def0);
    regRead(8'h80, 4'd8, rd); check(rd == 64'h1234_5678_9abc_def0, "R1 8-byte write", rd, 64'h1234_5678_9abc_def0);
    regRead(8'h80, 4'd4, rd); check(rd == 64'h9abc_def0, "R1 4-byte read", rd, 64'h9abc_def0);
    regWrite(8'h88, 4'd4, 64'hffff_ffff_0bad_cafe);
    regRead(8'h88, 4'd8, rd); check(rd == 64'h0bad_cafe, "R1 4-byte write zero-extends", rd, 64'h0bad_cafe);
    regRead(8'h84, 4'd8, rd); check(rd == 0, "R1 unmapped offset reads zero", rd, 0);

    // R2: odd sizes
    regWrite(8'h90, 4'd8, 64'h55);
    regWrite(8'h90, 4'd2, 64'h77);
    regRead(8'h90, 4'd8, rd); check(rd == 64'h55, "R2 size-2 write ignored", rd, 64'h55);
    regRead(8'h90, 4'd1, rd); check(rd == '1, "R2 size-1 read all ones", rd, '1);

    // R3: command without run
    regWrite(8'h98, 4'd8, 64'h6);
    regRead(8'h98, 4'd8, rd); check(rd == 0, "R3 cmd unchanged", rd, 0);
    reqs = 0;
    repeat (Dly + 5) begin @(negedge clk); if (memReq) reqs++; end
    check(reqs == 0, "R3 no transfer started", 64'(reqs), 0);

    // R4: writes ignored while running
    for (int i = 0; i < 64; i++) shadow[i] = ext[16'h0100 + i];
    regWrite(8'h80, 4'd8, 64'h100);
    regWrite(8'h88, 4'd8, 64'h40000);
    regWrite(8'h90, 4'd8, 64'd64);
    regWrite(8'h98, 4'd8, 64'h1);
    regWrite(8'h80, 4'd8, 64'hdead);
    regWrite(8'h98, 4'd8, 64'h7);
    regWrite(8'h90, 4'd4, 64'h3);
    begin
      int k = 0;
      forever begin
        regRead(8'h98, 4'd8, rd);
        if (!rd[0] || k > 5000) break;
        @(negedge clk); k++;
      end
    end
    regRead(8'h80, 4'd8, rd); check(rd == 64'h100, "R4 src frozen during run", rd, 64'h100);
    regRead(8'h90, 4'd8, rd); check(rd == 64'd64, "R4 cnt frozen during run", rd, 64);
    regRead(8'h98, 4'd8, rd); check(rd == 64'h0, "R4 cmd kept, run cleared", rd, 0);

    // R5..R7, R9: random transfers in, then out
    for (int t = 0; t < 14; t++) begin
      cnt = (t == 0) ? 4096 : (t == 1) ? 1 : (t == 2) ? 7 : int'($urandom_range(64, 1));
      off = (t == 0) ? 0 : (t == 1) ? 4095 : int'($urandom_range(4096 - cnt, 0));
      hiJunk = {4'(t), 32'($urandom), 28'h0};
      src = hiJunk | 64'($urandom_range(16'h5000, 0));
      cmd = 64'h1 | (64'($urandom_range(1, 0)) << 2);
      doXfer(src, 64'h40000 + 64'(off), 64'(cnt), cmd, irqs, first, fa, reqs);
      for (int i = 0; i < cnt; i++) shadow[off + i] = ext[16'(src[15:0] + 16'(i))];
      check(first == Dly, $sformatf("R5 start delay in t%0d", t), 64'(first), 64'(Dly));
      check(fa == src[AW-1:0], $sformatf("R7 masked source t%0d", t), 64'(fa), 64'(src[AW-1:0]));
      check(irqs == int'(cmd[2]), $sformatf("R9 irq count in t%0d", t), 64'(irqs), 64'(cmd[2]));

      dst = hiJunk | 64'(16'h8000 + 16'($urandom_range(16'h6000, 0)));
      for (int i = 0; i < 65536; i++) saved[i] = ext[i];
      cmd = 64'h3 | (64'($urandom_range(1, 0)) << 2);
      doXfer(64'h40000 + 64'(off), dst, 64'(cnt), cmd, irqs, first, fa, reqs);
      bad = cmpOut(off, int'(dst[15:0]), cnt);
      check(bad == 0, $sformatf("R6 round trip bytes t%0d cnt %0d", t, cnt), 64'(bad), 0);
      check(fa == dst[AW-1:0], $sformatf("R7 masked destination t%0d", t), 64'(fa), 64'(dst[AW-1:0]));
      check(irqs == int'(cmd[2]), $sformatf("R9 irq count out t%0d", t), 64'(irqs), 64'(cmd[2]));
    end

    // R8: bounds violations (flag is sticky, so these run last)
    check(!errFlag, "R8 no error before violations", 64'(errFlag), 0);
    doXfer(64'h0, 64'h40FFE, 64'd3, 64'h5, irqs, first, fa, reqs);
    check(reqs == 0 && irqs == 0, "R8 overrun end refused", 64'(reqs + irqs), 0);
    check(errFlag, "R8 error flag set", 64'(errFlag), 1);
    regRead(8'h98, 4'd8, rd); check(rd[0] == 1'b0, "R8 run cleared", rd, 64'h4);
    doXfer(64'h3FFFF, 64'h0, 64'd4, 64'h7, irqs, first, fa, reqs);
    check(reqs == 0 && irqs == 0, "R8 below window refused", 64'(reqs + irqs), 0);
    doXfer(64'h0, 64'h40010, 64'd0, 64'h5, irqs, first, fa, reqs);
    check(reqs == 0 && irqs == 0, "R8 zero count refused", 64'(reqs + irqs), 0);
    doXfer(64'h0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h40020, 64'h5, irqs, first, fa, reqs);
    check(reqs == 0 && irqs == 0, "R8 wrapping range refused", 64'(reqs + irqs), 0);
    check(errFlag, "R8 error flag sticky", 64'(errFlag), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule